// File: doc/BRIEF.md
# Multicycle Six-Instruction Processor Core

This block is a small processor core that runs one instruction over several clock cycles. It has a program counter, an instruction register, a bank of 32 general registers in which register 0 always reads as zero, an arithmetic unit that can add, OR and subtract, and a unified word memory that holds both code and data. A single state machine steps every instruction through fetch and decode. It then runs an execution path chosen by the opcode in the top six bits of the instruction word.

While reset is held, the memory is filled from address 0 through a load port. Releasing reset starts execution at byte address 0. Instructions are 32 bits wide and the program counter moves in steps of 4. When the core meets the exit instruction it parks in a halt state and raises `halted`. Two combinational peek ports then let the environment read any register and any memory word.

States: FETCH, DECODE, ADDR (address add), MRD (memory read), LWB (load writeback), MWR (memory write), EXEC (register add), RWB (register writeback), ORI (OR with immediate), IWB (immediate writeback), BCMP (branch compare), BTAKE (branch taken), HALT. Transitions:
- FETCH goes to DECODE.
- DECODE goes to ADDR for lw and sw, to EXEC for add, to ORI for ori, to BCMP for beq and to HALT for exit. Any other opcode returns to FETCH.
- ADDR goes to MRD for lw and to MWR for sw. MRD goes to LWB.
- EXEC goes to RWB, and ORI goes to IWB.
- BCMP goes to BTAKE when its operands are equal, and to FETCH otherwise.
- LWB, MWR, RWB, IWB and BTAKE all return to FETCH.
- HALT stays in HALT.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted, every register reads 0 and `halted` is 0. After release, the first fetch is from byte address 0.
- R2: Each instruction spends one FETCH and one DECODE cycle and then a fixed number of further cycles: lw 3, sw 2, add 2, ori 2, beq not taken 1, beq taken 2, exit 0, unrecognised opcode 0.
- R3: add (opcode 000000) writes rs[25:21] + rt[20:16] into rd[15:11], whatever the value of bits [5:0].
- R4: ori (opcode 001101) writes rs OR the zero-extended immediate [15:0] into rt.
- R5: lw (opcode 100100) reads the word at byte address rs + sign-extended immediate and writes it into rt. The word index is address bits [MEM_AW+1:2].
- R6: sw (opcode 101100) stores rt at byte address rs + sign-extended immediate, and no other word changes.
- R7: beq (opcode 000100) loads PC+4+(sign-extended immediate << 2) when rs equals rt, and continues at PC+4 otherwise. The PC is always word aligned.
- R8: Register 0 reads as 0, and a write to it is discarded.
- R9: exit (opcode 111111) stops the core. `halted` stays at 1 and the PC, registers and memory stay unchanged until reset.
- R10: An instruction with any other opcode changes no register or memory word, and execution continues with the next word.
- R11: The load port writes memory only while reset is asserted. A load pulse while running or halted has no effect.
- R12: A program that sums 1 to 63 leaves 0x7E0 in its result word when it halts, after 972 cycles.
- R13: The peek ports show the selected register or memory word combinationally. After halt they show the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, which also enables loading |
| ld_en | input | 1 | Load strobe, honoured only during reset |
| ld_addr | input | MEM_AW | Word index to load |
| ld_data | input | 32 | Word to load |
| halted | output | 1 | Core has executed exit |
| peek_reg_sel | input | 5 | Register to observe |
| peek_reg_data | output | 32 | Value of the selected register |
| peek_mem_addr | input | MEM_AW | Memory word to observe |
| peek_mem_data | output | 32 | Value of the selected memory word |

## Verification
The hardest case to reach is a taken branch. The branch target is formed during decode, before the compare, and must survive the compare cycle unchanged in the holding register. A loop only terminates correctly when both backward and forward branches land, so the summing program runs 63 iterations and then exits through a forward taken branch. A second program reaches the other corners from the ports: a not-taken branch, negative load and store offsets, a write to register 0, an add with a foreign function field and an unknown opcode. Its exact total cycle count pins down the number of cycles each instruction path takes.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam logic [5:0] OP_ADD  = 6'b000000;
    localparam logic [5:0] OP_ORI  = 6'b001101;
    localparam logic [5:0] OP_BEQ  = 6'b000100;
    localparam logic [5:0] OP_LW   = 6'b100100;
    localparam logic [5:0] OP_SW   = 6'b101100;
    localparam logic [5:0] OP_EXIT = 6'b111111;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ADDR, ST_MRD, ST_LWB, ST_MWR, ST_EXEC,
        ST_RWB, ST_ORI, ST_IWB, ST_BCMP, ST_BTAKE, ST_HALT
    } state_t;

    typedef enum logic [1:0] { ALU_ADD, ALU_OR, ALU_SUB } alu_op_t;

    // operand B choices
    localparam logic [1:0] SRCB_REG   = 2'd0;
    localparam logic [1:0] SRCB_FOUR  = 2'd1;
    localparam logic [1:0] SRCB_IMM   = 2'd2;
    localparam logic [1:0] SRCB_IMMX4 = 2'd3;

    typedef struct packed {
        logic       ir_we;
        logic       pc_we;
        logic       pc_from_hold;  // 1: PC from ALU holding register
        logic       addr_from_alu; // 1: memory address from holding register
        logic       src_a_reg;     // 1: operand A from register A
        logic [1:0] src_b;
        alu_op_t    alu_op;
        logic       ab_we;
        logic       hold_we;
        logic       mdr_we;
        logic       mem_we;
        logic       rf_we;
        logic       dst_rd;        // 1: write rd, 0: write rt
        logic       wb_mem;        // 1: write data from memory register
        logic       imm_zext;
    } ctl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_t      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [SW-1:0] ra1,
    input  logic [SW-1:0] ra2,
    input  logic [SW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    input  logic       zero,
    output state_t     state,
    output ctl_t       ctl
);
    state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OP_LW, OP_SW: nxt = ST_ADDR;
                    OP_ADD:       nxt = ST_EXEC;
                    OP_ORI:       nxt = ST_ORI;
                    OP_BEQ:       nxt = ST_BCMP;
                    OP_EXIT:      nxt = ST_HALT;
                    default:      nxt = ST_FETCH;
                endcase
            end
            ST_ADDR:   nxt = (opcode == OP_LW) ? ST_MRD : ST_MWR;
            ST_MRD:    nxt = ST_LWB;
            ST_EXEC:   nxt = ST_RWB;
            ST_ORI:    nxt = ST_IWB;
            ST_BCMP:   nxt = zero ? ST_BTAKE : ST_FETCH;
            ST_LWB, ST_MWR, ST_RWB, ST_IWB, ST_BTAKE: nxt = ST_FETCH;
            ST_HALT:   nxt = ST_HALT;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_FETCH: begin
                ctl.ir_we = 1'b1;
                ctl.pc_we = 1'b1;
                ctl.src_b = SRCB_FOUR;
            end
            ST_DECODE: begin
                ctl.src_b   = SRCB_IMMX4;
                ctl.ab_we   = 1'b1;
                ctl.hold_we = 1'b1;
            end
            ST_ADDR: begin
                ctl.src_a_reg = 1'b1;
                ctl.src_b     = SRCB_IMM;
                ctl.hold_we   = 1'b1;
            end
            ST_MRD:  begin
                ctl.addr_from_alu = 1'b1;
                ctl.mdr_we        = 1'b1;
            end
            ST_LWB:  begin
                ctl.rf_we  = 1'b1;
                ctl.wb_mem = 1'b1;
            end
            ST_MWR:  begin
                ctl.addr_from_alu = 1'b1;
                ctl.mem_we        = 1'b1;
            end
            ST_EXEC: begin
                ctl.src_a_reg = 1'b1;
                ctl.hold_we   = 1'b1;
            end
            ST_RWB:  begin
                ctl.rf_we  = 1'b1;
                ctl.dst_rd = 1'b1;
            end
            ST_ORI:  begin
                ctl.src_a_reg = 1'b1;
                ctl.src_b     = SRCB_IMM;
                ctl.alu_op    = ALU_OR;
                ctl.imm_zext  = 1'b1;
                ctl.hold_we   = 1'b1;
            end
            ST_IWB:  ctl.rf_we = 1'b1;
            ST_BCMP: begin
                ctl.src_a_reg = 1'b1;
                ctl.alu_op    = ALU_SUB;
            end
            ST_BTAKE: begin
                ctl.pc_we        = 1'b1;
                ctl.pc_from_hold = 1'b1;
            end
            ST_HALT: ctl = '0;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    localparam int MEM_AW = $clog2(MEM_WORDS),
    localparam int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [W-1:0]      ld_data,
    output logic              halted,
    input  logic [4:0]        peek_reg_sel,
    output logic [W-1:0]      peek_reg_data,
    input  logic [MEM_AW-1:0] peek_mem_addr,
    output logic [W-1:0]      peek_mem_data
);
    state_t state;
    ctl_t   ctl;

    logic [W-1:0] pc_q, ir_q, a_q, b_q, hold_q, mdr_q;
    logic [W-1:0] rd1, rd2, alu_a, alu_b, alu_y, imm_ext, wb_data, mem_rdata;
    logic         alu_zero;
    logic [MEM_AW-1:0] mem_idx;
    logic [W-1:0] mem [MEM_WORDS];

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir_q[31:26]),
        .zero   (alu_zero),
        .state  (state),
        .ctl    (ctl)
    );

    mc_regfile #(.W(W), .N(32)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (ctl.rf_we),
        .wa  (ctl.dst_rd ? ir_q[15:11] : ir_q[20:16]),
        .wd  (wb_data),
        .ra1 (ir_q[25:21]),
        .ra2 (ir_q[20:16]),
        .ra3 (peek_reg_sel),
        .rd1 (rd1),
        .rd2 (rd2),
        .rd3 (peek_reg_data)
    );

    assign imm_ext = ctl.imm_zext ? {16'b0, ir_q[15:0]} : {{16{ir_q[15]}}, ir_q[15:0]};
    assign alu_a   = ctl.src_a_reg ? a_q : pc_q;

    always_comb begin
        unique case (ctl.src_b)
            SRCB_FOUR:  alu_b = 32'd4;
            SRCB_IMM:   alu_b = imm_ext;
            SRCB_IMMX4: alu_b = {imm_ext[W-3:0], 2'b00};
            default:    alu_b = b_q;
        endcase
    end

    mc_alu #(.W(W)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wb_data   = ctl.wb_mem ? mdr_q : hold_q;
    assign mem_idx   = ctl.addr_from_alu ? hold_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];
    assign mem_rdata = mem[mem_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_en) mem[ld_addr] <= ld_data;
        end else if (ctl.mem_we) begin
            mem[mem_idx] <= b_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ir_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
            hold_q <= '0;
            mdr_q  <= '0;
        end else begin
            if (ctl.pc_we)   pc_q   <= ctl.pc_from_hold ? hold_q : alu_y;
            if (ctl.ir_we)   ir_q   <= mem_rdata;
            if (ctl.ab_we)   begin a_q <= rd1; b_q <= rd2; end
            if (ctl.hold_we) hold_q <= alu_y;
            if (ctl.mdr_we)  mdr_q  <= mem_rdata;
        end
    end

    assign halted        = (state == ST_HALT);
    assign peek_mem_data = mem[peek_mem_addr];
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        halted,
    input logic [31:0] pc,
    input logic [31:0] ir,
    input state_t      st,
    input logic [4:0]  peek_reg_sel,
    input logic [31:0] peek_reg_data
);
    assert_pc_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_pc_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc));

    assert_r0_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (peek_reg_sel == 5'd0) |-> (peek_reg_data == 32'd0));

    assert_ir_only_in_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (st != ST_DECODE) |-> $stable(ir));
endmodule

bind mc_core mc_core_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .halted        (halted),
    .pc            (pc_q),
    .ir            (ir_q),
    .st            (state),
    .peek_reg_sel  (peek_reg_sel),
    .peek_reg_data (peek_reg_data)
);

// File: tb/sim_mc_core.sv
module sim_mc_core;
    localparam int MW = 64;
    localparam int AW = $clog2(MW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic          halted;
    logic [4:0]    peek_reg_sel = '0;
    logic [31:0]   peek_reg_data;
    logic [AW-1:0] peek_mem_addr = '0;
    logic [31:0]   peek_mem_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mc_core #(.MEM_WORDS(MW)) u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .halted(halted), .peek_reg_sel(peek_reg_sel), .peek_reg_data(peek_reg_data),
        .peek_mem_addr(peek_mem_addr), .peek_mem_data(peek_mem_data)
    );

    typedef struct {
        bit          is_mem;
        int          idx;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    bit          mon_req = 1'b0;
    logic [31:0] img [MW];

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int funct);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(funct)};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic push_reg(int idx, logic [31:0] v, string tag);
        exp_t e;
        e.is_mem = 1'b0; e.idx = idx; e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_mem(int idx, logic [31:0] v, string tag);
        exp_t e;
        e.is_mem = 1'b1; e.idx = idx; e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares queued expectations with the peek ports
    initial begin
        forever begin
            wait (mon_req);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_mem) begin
                    peek_mem_addr = AW'(e.idx);
                    #1;
                    chk(e.tag, peek_mem_data, e.val);
                end else begin
                    peek_reg_sel = 5'(e.idx);
                    #1;
                    chk(e.tag, peek_reg_data, e.val);
                end
            end
            mon_req = 1'b0;
        end
    endtask_dummy: begin end
    end

    task automatic scoreboard_drain();
        mon_req = 1'b1;
        wait (!mon_req);
    endtask

    task automatic load_image();
        rst = 1'b1;
        for (int i = 0; i < MW; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(i); ld_data = img[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(output int n);
        n = 0;
        @(negedge clk);
        rst = 1'b0;
        while (n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (halted) break;
        end
        if (!halted) begin
            fails++;
            $display("FAIL R9 watchdog: no halt actual=0 expected=1");
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // ---------- program 1: sum 1..63 ----------
        for (int i = 0; i < MW; i++) img[i] = 32'h0;
        img[0]  = enc_i(6'b001101, 0, 7, 1);        // ori r7,r0,1
        img[1]  = enc_i(6'b100100, 0, 8, 16'h30);   // lw r8,0x30(r0)
        img[2]  = enc_i(6'b001101, 0, 9, 0);        // ori r9,r0,0
        img[3]  = enc_i(6'b001101, 0, 10, 1);       // ori r10,r0,1
        img[4]  = enc_i(6'b000100, 8, 10, 3);       // beq r8,r10,+3
        img[5]  = enc_r(9, 10, 9, 6'h20);           // add r9,r9,r10
        img[6]  = enc_r(10, 7, 10, 6'h20);          // add r10,r10,r7
        img[7]  = enc_i(6'b000100, 0, 0, -4);       // beq r0,r0,-4
        img[8]  = enc_i(6'b101100, 0, 9, 16'h34);   // sw r9,0x34(r0)
        img[9]  = 32'hFC00_0000;                    // exit
        img[12] = 32'd64;
        load_image();
        // R1: reset state
        chk("R1 halted during reset", {31'b0, halted}, 32'd0);
        push_reg(9, 0, "R1 r9 reset");
        push_reg(31, 0, "R1 r31 reset");
        scoreboard_drain();
        run(n);
        chk("R12 sum program cycles", n, 972);
        chk("R9 halted after exit", {31'b0, halted}, 32'd1);
        push_mem(13, 32'h7E0, "R12 sum word");
        push_reg(9, 32'h7E0, "R3 r9 accumulated");
        push_reg(10, 32'd64, "R7 loop counter at exit");
        push_reg(8, 32'd64, "R5 lw limit");
        push_reg(7, 32'd1, "R4 ori r7");
        push_mem(12, 32'd64, "R6 limit word untouched");
        scoreboard_drain();

        // ---------- program 2: corners ----------
        for (int i = 0; i < MW; i++) img[i] = 32'h0;
        img[0]  = enc_i(6'b001101, 0, 1, 16'hFFFF); // ori r1,r0,0xFFFF
        img[1]  = enc_i(6'b001101, 0, 0, 5);        // ori r0,r0,5
        img[2]  = enc_i(6'b001101, 0, 2, 16'h40);   // ori r2,r0,0x40
        img[3]  = enc_i(6'b100100, 2, 3, -4);       // lw r3,-4(r2)
        img[4]  = enc_i(6'b101100, 2, 1, -8);       // sw r1,-8(r2)
        img[5]  = enc_i(6'b000100, 1, 0, 1);        // beq r1,r0 not taken
        img[6]  = enc_r(1, 1, 4, 6'h20);            // add r4,r1,r1
        img[7]  = enc_r(1, 2, 5, 6'h22);            // add, odd funct
        img[8]  = enc_i(6'b001000, 0, 6, 7);        // unknown opcode
        img[9]  = enc_r(0, 3, 12, 6'h20);           // add r12,r0,r3
        img[10] = 32'hFC00_0000;                    // exit
        img[15] = 32'hCAFE_1234;
        load_image();
        push_reg(9, 0, "R1 r9 cleared by reset");
        scoreboard_drain();
        run(n);
        chk("R2 corner program cycles", n, 40);
        push_reg(1, 32'h0000_FFFF, "R4 ori zero-extend");
        push_reg(0, 32'h0, "R8 r0 write ignored");
        push_reg(3, 32'hCAFE_1234, "R5 lw negative offset");
        push_mem(14, 32'h0000_FFFF, "R6 sw negative offset");
        push_mem(15, 32'hCAFE_1234, "R6 neighbour word kept");
        push_reg(4, 32'h0001_FFFE, "R7 not-taken beq falls through");
        push_reg(5, 32'h0001_003F, "R3 add ignores funct");
        push_reg(6, 32'h0, "R10 unknown opcode no write");
        push_reg(12, 32'hCAFE_1234, "R8 r0 reads zero in add");
        scoreboard_drain();

        // R11: load pulse while halted is ignored
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(14); ld_data = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        ld_en = 1'b0;
        repeat (4) @(negedge clk);
        push_mem(14, 32'h0000_FFFF, "R11 load ignored out of reset");
        push_reg(5, 32'h0001_003F, "R9 registers frozen after halt");
        scoreboard_drain();
        chk("R9 halted sticky", {31'b0, halted}, 32'd1);
        peek_mem_addr = AW'(0);
        #1;
        chk("R13 peek memory word 0", peek_mem_data, img[0]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule